// File: doc/BRIEF.md
# Seven-to-One Parallel Pixel Serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and one forwarded-clock lane. A word is taken in once per pixel clock, on the rising or the falling edge as a select input chooses. It is carried into a bit clock that runs at exactly seven times the pixel rate, and each lane then shifts out one 7-bit slice of the word, lowest bit first. The fifth lane repeats a fixed 7-slot pattern once per frame, so a receiver can rebuild the pixel clock and find frame boundaries. The bit clock is supplied from outside, already locked to the pixel clock. Clock synthesis and the analog line drivers are not part of this block.

An active-low shutdown input clears every register in both clock domains at once and forces every output low. After shutdown is released, the outputs stay low until a complete word captured after the release has been loaded into the shifters. Serial output then begins on a frame boundary and continues without a gap. A matching 1:7 deserializer recovers the applied words unchanged and in order.

Top module: `lvds7_serializer`

## Requirements
- R1: Lane k (k = 0..3) carries data bits 7k through 7k+6 of the captured word, so lane 0 holds bits 0..6 and lane 3 holds bits 21..27.
- R2: Within a frame, serial slot s (s = 0..6, slot 0 first after the frame boundary) of lane k carries data bit 7k+s. The lowest-indexed bit goes first.
- R3: With edge_sel_i = 0 the word is captured on the rising edge of pix_clk_i. Data that is valid only around the falling edge is never transmitted.
- R4: With edge_sel_i = 1 the word is captured on the falling edge of pix_clk_i. Data that is valid only around the rising edge is never transmitted.
- R5: While oe_o is high, a new frame starts every 7 bit-clock cycles. Every captured word is sent exactly once, in capture order, with none skipped or repeated.
- R6: In frame slots 0..6, fclk_o carries the values 1,1,0,0,0,1,1, the same in every frame.
- R7: While shdn_n_i is low, lane_o, fclk_o and oe_o are all 0, starting from the moment shdn_n_i falls and including the state right after power-up.
- R8: After shdn_n_i rises, oe_o stays 0 until the first word captured after the release is loaded. oe_o rises within 28 bit-clock cycles of the release, and the first enabled slot is slot 0 of a frame.
- R9: Once oe_o is high, it stays high for as long as shdn_n_i stays high.
- R10: A shutdown discards any word in flight. The first non-zero frame after a release is the first word applied after that release, and any frame sent before it is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk_i | input | 1 | Pixel clock; one word is captured per period |
| bit_clk_i | input | 1 | Serial bit clock, locked at seven times the pixel clock |
| edge_sel_i | input | 1 | Capture edge: 0 rising, 1 falling |
| shdn_n_i | input | 1 | Active-low shutdown and clear |
| data_i | input | 28 | Parallel pixel word |
| lane_o | output | 4 | Serial data lanes, one bit per lane per bit clock |
| fclk_o | output | 1 | Forwarded-clock lane |
| oe_o | output | 1 | High while the serial outputs carry valid frames |

## Verification
If the frame phase counter is wrong, the forwarded-clock lane breaks its 1,1,0,0,0,1,1 shape in the first enabled frame, and the rebuilt word at that boundary is rotated. If the staging register misses an update or takes one twice, the recovered word sequence repeats or skips an entry one frame after the crossing. A swapped slice or a reversed bit order corrupts the first non-idle word. A capture on the wrong edge shows up in the first frame as a junk pattern that matches no applied word. A shutdown that does not clear is seen at the next bit-clock sample as a non-zero lane, or after the release as a stale word.

// File: rtl/lvser_pkg.sv
package lvser_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } cap_edge_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/lvser_capture.sv
module lvser_capture #(
   parameter int unsigned WIDTH        = 28,
   parameter bit          SUPPORT_FALL = 1'b1
) (
   input  logic             pix_clk_i,
   input  logic             rst_n_i,
   input  logic             edge_sel_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] hold_o,
   output logic             tog_o
);
   import lvser_pkg::*;

   logic [WIDTH-1:0] rise_q;
   logic             rise_tog_q;

   // rising-edge capture path, always present
   always_ff @(posedge pix_clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         rise_q     <= '0;
         rise_tog_q <= 1'b0;
      end else begin
         rise_q     <= data_i;
         rise_tog_q <= ~rise_tog_q;
      end
   end

   generate
      if (SUPPORT_FALL) begin : g_fall
         logic [WIDTH-1:0] fall_q;
         logic             fall_tog_q;

         always_ff @(negedge pix_clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
               fall_q     <= '0;
               fall_tog_q <= 1'b0;
            end else begin
               fall_q     <= data_i;
               fall_tog_q <= ~fall_tog_q;
            end
         end

         always_comb begin
            if (cap_edge_e'(edge_sel_i) == EDGE_FALL) begin
               hold_o = fall_q;
               tog_o  = fall_tog_q;
            end else begin
               hold_o = rise_q;
               tog_o  = rise_tog_q;
            end
         end
      end else begin : g_rise_only
         logic unused_sel;
         assign unused_sel = edge_sel_i;
         assign hold_o     = rise_q;
         assign tog_o      = rise_tog_q;
      end
   endgenerate

endmodule

// File: rtl/lvser_xfer.sv
module lvser_xfer #(
   parameter int unsigned WIDTH       = 28,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             bit_clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] hold_i,
   input  logic             tog_i,
   output logic [WIDTH-1:0] stage_o,
   output logic             have_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lvser_xfer: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES:0] sync_q;
   logic                 fresh_w;
   logic [WIDTH-1:0]     stage_q;
   logic                 have_q;

   always_ff @(posedge bit_clk_i or negedge rst_n_i) begin
      if (!rst_n_i) sync_q <= '0;
      else          sync_q <= {sync_q[SYNC_STAGES-1:0], tog_i};
   end

   // a toggle edge means the holding word changed and has since settled
   assign fresh_w = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

   always_ff @(posedge bit_clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         stage_q <= '0;
         have_q  <= 1'b0;
      end else if (fresh_w) begin
         stage_q <= hold_i;
         have_q  <= 1'b1;
      end
   end

   assign stage_o = stage_q;
   assign have_o  = have_q;

endmodule

// File: rtl/lvser_lane.sv
module lvser_lane #(
   parameter int unsigned SLOTS = 7
) (
   input  logic             bit_clk_i,
   input  logic             rst_n_i,
   input  logic             load_i,
   input  logic [SLOTS-1:0] par_i,
   output logic             ser_o
);

   logic [SLOTS-1:0] sh_q;

   always_ff @(posedge bit_clk_i or negedge rst_n_i) begin
      if (!rst_n_i)    sh_q <= '0;
      else if (load_i) sh_q <= par_i;
      else             sh_q <= {1'b0, sh_q[SLOTS-1:1]};
   end

   assign ser_o = sh_q[0];

endmodule

// File: rtl/lvds7_serializer.sv
module lvds7_serializer #(
   parameter int unsigned     LANES        = 4,
   parameter int unsigned     SLOTS        = 7,
   parameter logic [SLOTS-1:0] FWD_PATTERN = 7'b1100011,
   parameter int unsigned     SYNC_STAGES  = 2,
   parameter bit              SUPPORT_FALL = 1'b1
) (
   input  logic                   pix_clk_i,
   input  logic                   bit_clk_i,
   input  logic                   edge_sel_i,
   input  logic                   shdn_n_i,
   input  logic [LANES*SLOTS-1:0] data_i,
   output logic [LANES-1:0]       lane_o,
   output logic                   fclk_o,
   output logic                   oe_o
);
   import lvser_pkg::*;

   localparam int unsigned WIDTH = LANES * SLOTS;
   localparam int unsigned PW    = cnt_width(SLOTS);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("lvds7_serializer: LANES must be at least 1");
      end
      if (SLOTS < 2) begin : g_bad_slots
         $error("lvds7_serializer: SLOTS must be at least 2");
      end
   endgenerate

   // bit-domain reset: asserts at once, releases on the bit clock
   logic [1:0] rs_q;
   logic       bit_rst_n;

   always_ff @(posedge bit_clk_i or negedge shdn_n_i) begin
      if (!shdn_n_i) rs_q <= 2'b00;
      else           rs_q <= {rs_q[0], 1'b1};
   end
   assign bit_rst_n = rs_q[1];

   logic [WIDTH-1:0] hold_w;
   logic             tog_w;
   logic [WIDTH-1:0] stage_w;
   logic             have_w;

   lvser_capture #(
      .WIDTH       (WIDTH),
      .SUPPORT_FALL(SUPPORT_FALL)
   ) u_cap (
      .pix_clk_i (pix_clk_i),
      .rst_n_i   (shdn_n_i),
      .edge_sel_i(edge_sel_i),
      .data_i    (data_i),
      .hold_o    (hold_w),
      .tog_o     (tog_w)
   );

   lvser_xfer #(
      .WIDTH      (WIDTH),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_xfer (
      .bit_clk_i(bit_clk_i),
      .rst_n_i  (bit_rst_n),
      .hold_i   (hold_w),
      .tog_i    (tog_w),
      .stage_o  (stage_w),
      .have_o   (have_w)
   );

   // frame phase: slot 0 is the frame boundary
   logic [PW-1:0] phase_q;
   logic          load_w;
   logic          oe_q;

   always_ff @(posedge bit_clk_i or negedge bit_rst_n) begin
      if (!bit_rst_n)                    phase_q <= '0;
      else if (phase_q == PW'(SLOTS-1))  phase_q <= '0;
      else                               phase_q <= phase_q + 1'b1;
   end

   assign load_w = have_w && (phase_q == '0);

   always_ff @(posedge bit_clk_i or negedge bit_rst_n) begin
      if (!bit_rst_n)  oe_q <= 1'b0;
      else if (load_w) oe_q <= 1'b1;
   end

   logic [LANES-1:0] ser_w;
   logic             fwd_w;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         lvser_lane #(.SLOTS(SLOTS)) u_lane (
            .bit_clk_i(bit_clk_i),
            .rst_n_i  (bit_rst_n),
            .load_i   (load_w),
            .par_i    (stage_w[l*SLOTS +: SLOTS]),
            .ser_o    (ser_w[l])
         );
         assign lane_o[l] = ser_w[l] & oe_q;
      end
   endgenerate

   lvser_lane #(.SLOTS(SLOTS)) u_fwd (
      .bit_clk_i(bit_clk_i),
      .rst_n_i  (bit_rst_n),
      .load_i   (load_w),
      .par_i    (FWD_PATTERN),
      .ser_o    (fwd_w)
   );

   assign fclk_o = fwd_w & oe_q;
   assign oe_o   = oe_q;

endmodule

// File: rtl/lvser_chk.sv
module lvser_chk #(
   parameter int unsigned      LANES   = 4,
   parameter int unsigned      SLOTS   = 7,
   parameter logic [SLOTS-1:0] PATTERN = 7'b1100011
) (
   input logic             bit_clk,
   input logic             shdn_n,
   input logic [LANES-1:0] lane,
   input logic             fclk,
   input logic             oe,
   input logic             load
);

   int unsigned slot_q;
   int unsigned gap_q;

   always_ff @(posedge bit_clk or negedge shdn_n) begin
      if (!shdn_n) begin
         slot_q <= 0;
         gap_q  <= 0;
      end else begin
         if (!oe)                    slot_q <= 0;
         else if (slot_q == SLOTS-1) slot_q <= 0;
         else                        slot_q <= slot_q + 1;
         if (load)                   gap_q <= 0;
         else if (gap_q < SLOTS)     gap_q <= gap_q + 1;
      end
   end

   // R7: everything silent while shut down
   always @(posedge bit_clk) begin
      if (!shdn_n) begin
         assert_quiet_in_shutdown_R7: assert (lane == '0 && !fclk && !oe)
            else $error("R7: outputs active during shutdown");
      end
   end

   // R6: forwarded clock follows the fixed slot pattern
   assert_fwd_pattern_R6: assert property (@(posedge bit_clk) disable iff (!shdn_n)
      oe |-> (fclk == PATTERN[slot_q]));

   // R5: one frame every SLOTS bit clocks while enabled
   assert_frame_spacing_R5: assert property (@(posedge bit_clk) disable iff (!shdn_n)
      (load && oe) |-> (gap_q == SLOTS-1));

   // R9: enable does not drop while running
   assert_enable_sticky_R9: assert property (@(posedge bit_clk) disable iff (!shdn_n)
      oe |=> oe);

   // R8: enable rises only through a frame load
   assert_enable_on_load_R8: assert property (@(posedge bit_clk) disable iff (!shdn_n)
      $rose(oe) |-> $past(load));

endmodule

bind lvds7_serializer lvser_chk #(
   .LANES  (LANES),
   .SLOTS  (SLOTS),
   .PATTERN(FWD_PATTERN)
) chk_i (
   .bit_clk(bit_clk_i),
   .shdn_n (shdn_n_i),
   .lane   (lane_o),
   .fclk   (fclk_o),
   .oe     (oe_o),
   .load   (load_w)
);

// File: tb/lvds7_serializer_tb.sv
module lvds7_serializer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LANES      = 4;
   localparam int SLOTS      = 7;
   localparam int W          = LANES * SLOTS;
   localparam int PIX_PERIOD = CLK_PERIOD * SLOTS;
   localparam int MAXW       = 256;
   localparam int OE_LIMIT   = 4 * SLOTS;
   localparam logic [SLOTS-1:0] PAT  = 7'b1100011;
   localparam logic [W-1:0]     JUNK = '1;

   logic          bit_clk  = 1'b0;
   logic          pix_clk  = 1'b0;
   logic          edge_sel = 1'b0;
   logic          shdn_n   = 1'b0;
   logic [W-1:0]  data     = '0;
   wire [LANES-1:0] lane;
   wire           fclk;
   wire           oe;

   lvds7_serializer dut_i (
      .pix_clk_i (pix_clk),
      .bit_clk_i (bit_clk),
      .edge_sel_i(edge_sel),
      .shdn_n_i  (shdn_n),
      .data_i    (data),
      .lane_o    (lane),
      .fclk_o    (fclk),
      .oe_o      (oe)
   );

   initial forever #(CLK_PERIOD/2) bit_clk = ~bit_clk;
   initial begin
      #3;
      forever #(PIX_PERIOD/2) pix_clk = ~pix_clk;
   end

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic logic [W-1:0] word_of(input int i);
      logic [13:0] v;
      v = i[13:0];
      return {~v, v ^ {v[6:0], v[13:7]}};
   endfunction

   logic [W-1:0] app [MAXW];
   int nw        = 0;
   int seg_first = 0;
   int seg_end   = 0;

   // receiver state
   int           rx_slot  = 0;
   logic [W-1:0] rx       = '0;
   bit           synced   = 1'b0;
   int           rx_exp   = 0;
   int           since_rel = 0;
   bit           oe_seen  = 1'b0;

   always @(negedge bit_clk) begin
      if (!shdn_n) begin
         chk(lane == '0 && !fclk && !oe, "R7 shutdown outputs", {lane, fclk, oe}, 0);
         rx_slot   = 0;
         synced    = 1'b0;
         oe_seen   = 1'b0;
         since_rel = 0;
      end else begin
         since_rel++;
         chk(!(oe_seen && !oe), "R9 enable held", oe, 1);
         if (oe) begin
            if (!oe_seen) begin
               oe_seen = 1'b1;
               chk(since_rel <= OE_LIMIT, "R8 enable delay", since_rel, OE_LIMIT);
            end
            chk(fclk == PAT[rx_slot], "R6 forwarded clock slot", fclk, PAT[rx_slot]);
            for (int l = 0; l < LANES; l++) rx[l*SLOTS + rx_slot] = lane[l];
            if (rx_slot == SLOTS-1) begin
               rx_slot = 0;
               if (!synced) begin
                  if (rx != '0) begin
                     synced = 1'b1;
                     chk(rx == app[seg_first], "R10 first word after release", rx, app[seg_first]);
                     rx_exp = seg_first + 1;
                  end
               end else if (rx_exp < seg_end) begin
                  chk(rx == app[rx_exp],
                      edge_sel ? "R4 R1 R2 R5 falling-edge word" : "R3 R1 R2 R5 rising-edge word",
                      rx, app[rx_exp]);
                  rx_exp++;
               end
            end else begin
               rx_slot++;
            end
         end
      end
   end

   task automatic wait_cap();
      if (edge_sel) @(negedge pix_clk);
      else          @(posedge pix_clk);
   endtask

   // word valid only around the chosen edge; junk around the other
   task automatic drive_words(input int n);
      for (int k = 0; k < n; k++) begin
         wait_cap();
         #17;
         data = JUNK;
         #35;
         data    = word_of(nw);
         app[nw] = data;
         nw++;
      end
      wait_cap();
      #17;
      data = '0;
   endtask

   task automatic run_seg(input bit sel, input int n, input bit full);
      edge_sel = sel;
      data     = '0;
      #(PIX_PERIOD*2);
      seg_first = nw;
      seg_end   = nw + n;
      @(posedge bit_clk);
      #2;
      shdn_n = 1'b1;
      drive_words(n);
      if (full) begin
         #(PIX_PERIOD*6);
         chk(synced && rx_exp == seg_end, "R5 all words delivered", rx_exp, seg_end);
      end
      @(posedge bit_clk);
      #2;
      shdn_n = 1'b0;
   endtask

   initial begin
      #1;
      chk(lane == '0 && !fclk && !oe, "R7 power-up state", {lane, fclk, oe}, 0);
      #(PIX_PERIOD*2);
      run_seg(1'b0, 48, 1'b1);
      run_seg(1'b1, 48, 1'b1);
      run_seg(1'b0, 12, 1'b0);
      run_seg(1'b1, 30, 1'b1);
      #(PIX_PERIOD*2);
      finish_run();
   end

   initial begin
      #(CLK_PERIOD*150000);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

endmodule